// File: doc/BRIEF.md
# Power-Down Clock Gater

This block sits between a bank of free-running clock sources and the pins that carry them to the board. A single asynchronous, active-low power-down request (`pd_n_i`) is brought into the domain of a reference clock, the CPU clock. The request is confirmed there over consecutive edges and turned into a run/stop decision. Each output clock has its own gate cell. The cell brings that decision, together with the output's enable bit, into the output's own clock domain and opens or closes the gate only while that clock is low. No output ever produces a shortened high pulse.

While power-down is held, every gated output is low and the oscillator-stop and VCO-stop indications are raised. When the request is withdrawn, both stop indications clear. A stabilisation count then runs in the reference domain, standing in for the PLL settling time, before the outputs are allowed to run again. A separate tristate request turns into per-output output-enable signals, which are deasserted while it is set. Clocks are modelled as digital signals; no analog PLL behaviour is represented.

Top module: `pdg_clk_gater`

## Requirements
- R1: While `rst_ni` is low, every `gclk_o` bit is 0, `osc_stop_o` and `vco_stop_o` are 0 and every `oe_o` bit is 0. After reset, the outputs first run once the stabilisation count has elapsed.
- R2: When `pd_n_i` is sampled 0 on two consecutive rising edges of `ref_clk_i`, power-down is accepted. `osc_stop_o` and `vco_stop_o` then both become 1 and stay 1 while `pd_n_i` stays 0.
- R3: After power-down is accepted, each gated output stops low at a falling edge of its own raw clock and stays low. No high pulse on any `gclk_o` bit is ever shorter than the high phase of its raw clock.
- R4: A low on `pd_n_i` that is sampled on only one rising edge of `ref_clk_i` is ignored. No stop indication rises, and outputs keep toggling.
- R5: When `pd_n_i` returns to 1, both stop indications fall on the third rising edge of `ref_clk_i` after the release. The outputs resume only after `STAB_CNT` further reference cycles, and the wake time never exceeds `MAX_WAKE` reference cycles.
- R6: An output whose bit in `en_mask_i` is 0 stays low and does not toggle, both in run and after a power-down and release cycle.
- R7: A change of an enable bit is applied to its output only while that output's raw clock is low. An output that restarts therefore begins with a full-width high phase.
- R8: One reference edge after `tristate_i` is sampled 1, every `oe_o` bit is 0. One reference edge after it is sampled 0, every `oe_o` bit is 1.
- R9: The two stop indications are 1 exactly while power-down is in force. Both are 0 during the run state and during the stabilisation count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| ref_clk_i | input | 1 | Reference (CPU) clock; samples the power-down request |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pd_n_i | input | 1 | Asynchronous active-low power-down request |
| clk_raw_i | input | N_OUT | Free-running source clocks, one per output |
| en_mask_i | input | N_OUT | Per-output enable, 1 lets the output run |
| tristate_i | input | 1 | Request to release all clock pins |
| gclk_o | output | N_OUT | Gated clock outputs |
| oe_o | output | N_OUT | Output enable per clock pin, 1 drives the pin |
| osc_stop_o | output | 1 | Oscillator stop indication, 1 in power-down |
| vco_stop_o | output | 1 | VCO stop indication, 1 in power-down |

## Verification
The bench sends a power-down pulse that covers exactly one reference edge. A design that reacted to a single sample would raise the stop flags and freeze the outputs for that pulse. It then times the release precisely. A synchroniser one stage short or long moves the stop-flag fall away from the third edge, and a missing stabilisation count lets the first gated edge appear too early. Every high pulse on every output is measured against its raw high phase, which catches gates that close or reopen in mid-pulse. Finally, a masked output is carried through a full power-down and release cycle to show that the release does not override its disable.

// File: rtl/pdg_pkg.sv
package pdg_pkg;
  typedef enum logic [1:0] {
    PD_WAKE = 2'd0,
    PD_RUN  = 2'd1,
    PD_DOWN = 2'd2
  } pd_state_e;
endpackage

// File: rtl/pdg_rst_sync.sv
module pdg_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb chain_d = {chain_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= '0;
    else         chain_q <= chain_d;
  end

  assign rst_no = chain_q[STAGES-1];
endmodule

// File: rtl/pdg_pd_ctrl.sv
module pdg_pd_ctrl
  import pdg_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int STAB_CNT    = 16
) (
  input  logic ref_clk_i,
  input  logic rst_ni,
  input  logic pd_n_i,
  output logic run_o,
  output logic osc_stop_o,
  output logic vco_stop_o
);
  localparam int CNT_W = (STAB_CNT > 1) ? $clog2(STAB_CNT + 1) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(STAB_CNT - 1);

  logic [SYNC_STAGES-1:0] pd_sync_q, pd_sync_d;
  logic                   hist_q, hist_d;
  logic                   low_twice, high_now;
  pd_state_e              state_q, state_d;
  logic [CNT_W-1:0]       cnt_q, cnt_d;
  logic                   cnt_en;
  logic                   run_q, osc_q, vco_q;

  always_comb begin
    pd_sync_d = {pd_sync_q[SYNC_STAGES-2:0], pd_n_i};
    hist_d    = pd_sync_q[SYNC_STAGES-1];
    low_twice = !pd_sync_q[SYNC_STAGES-1] && !hist_q;
    high_now  = pd_sync_q[SYNC_STAGES-1];
  end

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    cnt_en  = 1'b0;
    unique case (state_q)
      PD_WAKE: begin
        if (low_twice) begin
          state_d = PD_DOWN;
        end else if (cnt_q == CNT_LAST) begin
          state_d = PD_RUN;
        end else begin
          cnt_en = 1'b1;
          cnt_d  = cnt_q + 1'b1;
        end
      end
      PD_RUN: begin
        if (low_twice) state_d = PD_DOWN;
      end
      PD_DOWN: begin
        if (high_now) begin
          state_d = PD_WAKE;
          cnt_en  = 1'b1;
          cnt_d   = '0;
        end
      end
      default: state_d = PD_WAKE;
    endcase
  end

  always_ff @(posedge ref_clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pd_sync_q <= '1;
      hist_q    <= 1'b1;
      state_q   <= PD_WAKE;
      run_q     <= 1'b0;
      osc_q     <= 1'b0;
      vco_q     <= 1'b0;
    end else begin
      pd_sync_q <= pd_sync_d;
      hist_q    <= hist_d;
      state_q   <= state_d;
      run_q     <= (state_d == PD_RUN);
      osc_q     <= (state_d == PD_DOWN);
      vco_q     <= (state_d == PD_DOWN);
    end
  end

  always_ff @(posedge ref_clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign run_o      = run_q;
  assign osc_stop_o = osc_q;
  assign vco_stop_o = vco_q;
endmodule

// File: rtl/pdg_gate_cell.sv
module pdg_gate_cell #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic en_i,
  output logic gclk_o
);
  logic                   rst_n;
  logic [SYNC_STAGES-1:0] req_q, req_d;
  logic                   gate_q, gate_d;

  pdg_rst_sync #(.STAGES(2)) u_rst (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rst_no (rst_n)
  );

  always_comb begin
    req_d  = {req_q[SYNC_STAGES-2:0], run_i & en_i};
    gate_d = req_q[SYNC_STAGES-1];
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) req_q <= '0;
    else        req_q <= req_d;
  end

  // Gate register moves only on the falling edge, while the clock is low.
  always_ff @(negedge clk_i or negedge rst_n) begin
    if (!rst_n) gate_q <= 1'b0;
    else        gate_q <= gate_d;
  end

  assign gclk_o = clk_i & gate_q;
endmodule

// File: rtl/pdg_clk_gater.sv
module pdg_clk_gater #(
  parameter int N_OUT       = 4,
  parameter int SYNC_STAGES = 2,
  parameter int STAB_CNT    = 16,
  parameter int MAX_WAKE    = 32
) (
  input  logic             ref_clk_i,
  input  logic             rst_ni,
  input  logic             pd_n_i,
  input  logic [N_OUT-1:0] clk_raw_i,
  input  logic [N_OUT-1:0] en_mask_i,
  input  logic             tristate_i,
  output logic [N_OUT-1:0] gclk_o,
  output logic [N_OUT-1:0] oe_o,
  output logic             osc_stop_o,
  output logic             vco_stop_o
);
  logic             rst_ref_n;
  logic             run_ref;
  logic [N_OUT-1:0] oe_q, oe_d;

  if (STAB_CNT > MAX_WAKE) begin : g_cfg_check
    $error("stabilisation count exceeds the wake bound");
  end

  pdg_rst_sync #(.STAGES(2)) u_rst_ref (
    .clk_i  (ref_clk_i),
    .rst_ni (rst_ni),
    .rst_no (rst_ref_n)
  );

  pdg_pd_ctrl #(
    .SYNC_STAGES (SYNC_STAGES),
    .STAB_CNT    (STAB_CNT)
  ) u_ctrl (
    .ref_clk_i  (ref_clk_i),
    .rst_ni     (rst_ref_n),
    .pd_n_i     (pd_n_i),
    .run_o      (run_ref),
    .osc_stop_o (osc_stop_o),
    .vco_stop_o (vco_stop_o)
  );

  for (genvar gi = 0; gi < N_OUT; gi++) begin : g_cell
    pdg_gate_cell #(.SYNC_STAGES(SYNC_STAGES)) u_cell (
      .clk_i  (clk_raw_i[gi]),
      .rst_ni (rst_ni),
      .run_i  (run_ref),
      .en_i   (en_mask_i[gi]),
      .gclk_o (gclk_o[gi])
    );
  end

  always_comb oe_d = {N_OUT{~tristate_i}};

  always_ff @(posedge ref_clk_i or negedge rst_ref_n) begin
    if (!rst_ref_n) oe_q <= '0;
    else            oe_q <= oe_d;
  end

  assign oe_o = oe_q;
endmodule

// File: rtl/pdg_clk_gater_chk.sv
module pdg_clk_gater_chk #(
  parameter int N_OUT    = 4,
  parameter int MAX_WAKE = 32
) (
  input logic             ref_clk_i,
  input logic             rst_ref_n,
  input logic             pd_n_i,
  input logic             run_ref,
  input logic             tristate_i,
  input logic [N_OUT-1:0] oe_o,
  input logic             osc_stop_o,
  input logic             vco_stop_o
);
  localparam int WC_W = $clog2(MAX_WAKE + 2);
  logic [WC_W-1:0] wake_q;

  always_ff @(posedge ref_clk_i or negedge rst_ref_n) begin
    if (!rst_ref_n)                   wake_q <= '0;
    else if (run_ref || osc_stop_o)   wake_q <= '0;
    else if (wake_q != WC_W'(MAX_WAKE + 1)) wake_q <= wake_q + 1'b1;
  end

  AST_PD_CONFIRMED: assert property (@(posedge ref_clk_i) disable iff (!rst_ref_n)
    $rose(osc_stop_o) |-> (!$past(pd_n_i, 3) && !$past(pd_n_i, 4))); // R2 R4

  AST_RELEASE_SEEN: assert property (@(posedge ref_clk_i) disable iff (!rst_ref_n)
    $fell(vco_stop_o) |-> $past(pd_n_i, 3)); // R5

  AST_WAKE_BOUND: assert property (@(posedge ref_clk_i) disable iff (!rst_ref_n)
    wake_q <= WC_W'(MAX_WAKE)); // R5

  AST_NO_RUN_WHILE_STOP: assert property (@(posedge ref_clk_i) disable iff (!rst_ref_n)
    (osc_stop_o || vco_stop_o) |-> !run_ref); // R9

  AST_OE_OFF: assert property (@(posedge ref_clk_i) disable iff (!rst_ref_n)
    tristate_i |=> (oe_o == '0)); // R8

  AST_OE_ON: assert property (@(posedge ref_clk_i) disable iff (!rst_ref_n)
    !tristate_i |=> (oe_o == '1)); // R8
endmodule

bind pdg_clk_gater pdg_clk_gater_chk #(
  .N_OUT    (N_OUT),
  .MAX_WAKE (MAX_WAKE)
) i_chk (
  .ref_clk_i  (ref_clk_i),
  .rst_ref_n  (rst_ref_n),
  .pd_n_i     (pd_n_i),
  .run_ref    (run_ref),
  .tristate_i (tristate_i),
  .oe_o       (oe_o),
  .osc_stop_o (osc_stop_o),
  .vco_stop_o (vco_stop_o)
);

// File: tb/test_pdg_clk_gater.sv
`timescale 1ns/1ps
module test_pdg_clk_gater;
  localparam int N   = 4;
  localparam int STB = 16;
  localparam int MXW = 32;

  logic         ref_clk, rst_n, pd_n, tri_s;
  logic [N-1:0] raw, mask, gclk, oe;
  logic         osc_stop, vco_stop;

  int   checks = 0;
  int   errors = 0;
  bit   done   = 0;
  int   rises [N];
  real  t_up  [N];
  int   runts  = 0;
  logic [N-1:0] prev = '0;
  localparam real HALF [N] = '{10.0, 15.0, 20.0, 8.0};

  typedef struct {
    string        tag;
    logic [N-1:0] act;
    logic         stop;
  } exp_t;
  exp_t sb[$];

  pdg_clk_gater #(.N_OUT(N), .STAB_CNT(STB), .MAX_WAKE(MXW)) i_pdg_clk_gater (
    .ref_clk_i(ref_clk), .rst_ni(rst_n), .pd_n_i(pd_n), .clk_raw_i(raw),
    .en_mask_i(mask), .tristate_i(tri_s), .gclk_o(gclk), .oe_o(oe),
    .osc_stop_o(osc_stop), .vco_stop_o(vco_stop));

  initial begin ref_clk = 0; forever #10 ref_clk = ~ref_clk; end
  initial begin raw[0] = 0; #3; forever #10 raw[0] = ~raw[0]; end
  initial begin raw[1] = 0; #5; forever #15 raw[1] = ~raw[1]; end
  initial begin raw[2] = 0; #7; forever #20 raw[2] = ~raw[2]; end
  initial begin raw[3] = 0; #1; forever #8  raw[3] = ~raw[3]; end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  // Edge and pulse-width monitor for all gated outputs (R3, R7)
  always @(gclk) begin
    for (int k = 0; k < N; k++) begin
      if (gclk[k] === 1'b1 && prev[k] !== 1'b1) begin
        rises[k]++;
        t_up[k] = $realtime;
      end
      if (gclk[k] === 1'b0 && prev[k] === 1'b1) begin
        if (($realtime - t_up[k]) < HALF[k] - 0.01) runts++;
      end
    end
    prev = gclk;
  end

  // Scoreboard monitor
  initial begin
    forever begin
      exp_t it;
      int   base [N];
      int   bad;
      logic [N-1:0] seen;
      wait (sb.size() > 0);
      it  = sb[0];
      bad = 0;
      for (int k = 0; k < N; k++) base[k] = rises[k];
      repeat (25) begin
        @(negedge ref_clk);
        if (osc_stop !== it.stop || vco_stop !== it.stop) bad++;
      end
      for (int k = 0; k < N; k++) seen[k] = (rises[k] != base[k]);
      check(seen == it.act, {it.tag, " activity"}, 32'(seen), 32'(it.act));
      check(bad == 0, {it.tag, " stop flags"}, 32'(bad), 32'(0));
      void'(sb.pop_front());
    end
  end

  task automatic expect_state(input string tag, input logic [N-1:0] act, input logic stop);
    exp_t it;
    it.tag = tag; it.act = act; it.stop = stop;
    sb.push_back(it);
    wait (sb.size() == 0);
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    real t_rel;
    int  n;
    rst_n = 0; pd_n = 1; tri_s = 0; mask = '1;
    repeat (6) @(negedge ref_clk);
    // R1: reset state
    check(gclk == '0, "R1 gclk in reset", 32'(gclk), 0);
    check(osc_stop === 1'b0 && vco_stop === 1'b0, "R1 stop flags in reset", {osc_stop, vco_stop}, 0);
    check(oe == '0, "R1 oe in reset", 32'(oe), 0);
    rst_n = 1;
    repeat (STB + 12) @(negedge ref_clk);
    expect_state("R1 running after wake", '1, 1'b0);

    // R8: tristate request
    tri_s = 1;
    @(negedge ref_clk);
    check(oe == '0, "R8 oe off", 32'(oe), 0);
    tri_s = 0;
    @(negedge ref_clk);
    check(oe == '1, "R8 oe on", 32'(oe), 32'(4'hf));

    // R4: low seen on one reference edge only
    pd_n = 0;
    @(negedge ref_clk);
    pd_n = 1;
    expect_state("R4 single-edge pulse ignored", '1, 1'b0);

    // R2 R3 R9: confirmed power-down
    pd_n = 0;
    repeat (12) @(negedge ref_clk);
    expect_state("R2 R3 power-down", '0, 1'b1);

    // R5: release timing
    pd_n = 1;
    t_rel = $realtime;
    n = 0;
    do begin @(negedge ref_clk); n++; end while (osc_stop === 1'b1 && n < 20);
    check(n == 3, "R5 stop flags fall on third edge", n, 3);
    check(vco_stop === 1'b0, "R9 vco stop clear in wake", 32'(vco_stop), 0);
    @(posedge gclk[0]);
    check(($realtime - t_rel) >= (3 + STB) * 20.0 && ($realtime - t_rel) <= (3 + MXW) * 20.0,
          "R5 first edge after stabilisation", int'($realtime - t_rel), (3 + STB) * 20);
    repeat (8) @(negedge ref_clk);
    expect_state("R5 resumed", '1, 1'b0);

    // R6: masked output stays low, also through power-down and release
    mask[2] = 0;
    repeat (10) @(negedge ref_clk);
    expect_state("R6 masked in run", 4'b1011, 1'b0);
    check(gclk[2] === 1'b0, "R6 masked output low", 32'(gclk[2]), 0);
    pd_n = 0;
    repeat (12) @(negedge ref_clk);
    expect_state("R6 masked in power-down", '0, 1'b1);
    pd_n = 1;
    repeat (STB + 14) @(negedge ref_clk);
    expect_state("R6 masked after release", 4'b1011, 1'b0);

    // R7: enable changes in mid-phase, including a short disable
    @(posedge gclk[1]); #3;
    mask[1] = 0;
    repeat (3) @(negedge ref_clk);
    mask[2] = 1;
    @(posedge raw[1]); #2;
    mask[1] = 1;
    repeat (10) @(negedge ref_clk);
    expect_state("R7 all restored", '1, 1'b0);
    check(runts == 0, "R3 R7 no shortened high pulse", runts, 0);
    finish_run();
  end
endmodule